// File: doc/BRIEF.md
# Prioritized Scratchpad Port Arbiter

This block sits in front of a single-ported on-chip scratchpad and shares it among three clients: a bulk-transfer engine, a load/store unit and an instruction fetcher. In every cycle at most one of them reaches the memory. The bulk-transfer engine always wins. The load/store unit comes next, and the fetcher is served last. A grant is combinational, in the same cycle as the request. A client that is not granted holds its request and waits.

Bulk transfers and fetches move a whole 128-byte line per access. Load/store accesses move one 16-byte segment of a line. A request whose address is not aligned to its own access size is retired with an error pulse and never touches the array.

Read results come back on one shared return bus. They arrive a fixed six cycles after the grant and carry a tag naming the client that asked, so each unit can pick out its own data.

Top module: `scratch_arbiter`

## Requirements
- R1: In any cycle at most one grant output is high, and a grant is only given to a client whose request is high in that same cycle.
- R2: Priority is fixed. The bulk-transfer request beats the load/store request, and both beat the fetch request.
- R3: A client that is not granted keeps its request high and is granted in a later cycle. No request is lost.
- R4: Bulk-transfer and fetch accesses cover the full 128-byte line chosen by address bits above bit 6. A bulk write replaces the whole line.
- R5: A load/store access covers the 16-byte segment chosen by address bits [6:4]. A load/store write changes only that segment of its line.
- R6: For a granted, aligned read, rdValid is high in the sixth cycle after the grant cycle, and is low in every other cycle.
- R7: rdTag gives the requester of the returned read: 0 for bulk transfer, 1 for load/store, 2 for fetch.
- R8: A load/store read returns its 16 bytes in rdData[127:0], with every higher bit zero. A wide read returns the whole line.
- R9: A request is misaligned when a load/store address has bits [3:0] not all zero, or when a wide address has bits [6:0] not all zero. A misaligned request is granted with its error output high in the same cycle. It performs no memory access and produces no read return.
- R10: While rstN is low, no grant or error output is high and rdValid is low.
- R11: Writes produce no read return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaReq | input | 1 | Bulk-transfer request |
| dmaWr | input | 1 | Bulk-transfer write (1) or read (0) |
| dmaAddr | input | AW | Bulk-transfer byte address |
| dmaWdata | input | 1024 | Bulk-transfer write line |
| dmaGnt | output | 1 | Bulk-transfer grant |
| dmaErr | output | 1 | Bulk-transfer misalignment error |
| lsReq | input | 1 | Load/store request |
| lsWr | input | 1 | Load/store write (1) or read (0) |
| lsAddr | input | AW | Load/store byte address |
| lsWdata | input | 128 | Load/store write segment |
| lsGnt | output | 1 | Load/store grant |
| lsErr | output | 1 | Load/store misalignment error |
| ifReq | input | 1 | Fetch request (read only) |
| ifAddr | input | AW | Fetch byte address |
| ifGnt | output | 1 | Fetch grant |
| ifErr | output | 1 | Fetch misalignment error |
| rdValid | output | 1 | Read return valid |
| rdTag | output | 2 | Requester of the returned read |
| rdData | output | 1024 | Returned read data |

## Verification
The assertions assume that the request and write inputs are driven to known values from reset onward. They also assume that the address and data of a waiting client stay unchanged until its grant. The stimulus meets both conditions. It changes inputs only just after a clock edge, and it lowers or replaces a request only in the cycle after that request was granted. Alignment faults are injected on purpose but rarely, so that the random traffic still mostly exercises real reads and writes against the reference copy of the array.

// File: rtl/sparb_pkg.sv
package sparb_pkg;
  localparam int RD_LAT = 6;

  typedef enum logic [1:0] {
    ID_DMA = 2'd0,
    ID_LS  = 2'd1,
    ID_IF  = 2'd2
  } reqId_e;

  typedef struct packed {
    logic   rd;
    logic   wr;
    logic   wide;
    reqId_e id;
  } memStrb_t;
endpackage

// File: rtl/sparb_ctrl.sv
module sparb_ctrl
  import sparb_pkg::*;
#(
  parameter int MEM_BYTES    = 262144,
  parameter int NARROW_BYTES = 16,
  parameter int WIDE_BYTES   = 128,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int WOFF = $clog2(WIDE_BYTES),
  localparam int NOFF = $clog2(NARROW_BYTES),
  localparam int LW   = AW - WOFF,
  localparam int SW   = WOFF - NOFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dmaReq,
  input  logic          dmaWr,
  input  logic [AW-1:0] dmaAddr,
  input  logic          lsReq,
  input  logic          lsWr,
  input  logic [AW-1:0] lsAddr,
  input  logic          ifReq,
  input  logic [AW-1:0] ifAddr,
  output logic          dmaGnt,
  output logic          lsGnt,
  output logic          ifGnt,
  output logic          dmaErr,
  output logic          lsErr,
  output logic          ifErr,
  output memStrb_t      strb,
  output logic [LW-1:0] memLine,
  output logic [SW-1:0] memSeg
);
  logic dmaWin, lsWin, ifWin;
  logic dmaOk, lsOk, ifOk;

  always_comb begin
    dmaWin  = rstN & dmaReq;
    lsWin   = rstN & lsReq & ~dmaReq;
    ifWin   = rstN & ifReq & ~dmaReq & ~lsReq;
    dmaOk   = (dmaAddr[WOFF-1:0] == '0);
    lsOk    = (lsAddr[NOFF-1:0] == '0);
    ifOk    = (ifAddr[WOFF-1:0] == '0);
    strb    = '0;
    memLine = '0;
    memSeg  = '0;
    if (dmaWin) begin
      strb.id   = ID_DMA;
      strb.wide = 1'b1;
      strb.rd   = dmaOk & ~dmaWr;
      strb.wr   = dmaOk & dmaWr;
      memLine   = dmaAddr[AW-1:WOFF];
    end else if (lsWin) begin
      strb.id   = ID_LS;
      strb.wide = 1'b0;
      strb.rd   = lsOk & ~lsWr;
      strb.wr   = lsOk & lsWr;
      memLine   = lsAddr[AW-1:WOFF];
      memSeg    = lsAddr[WOFF-1:NOFF];
    end else if (ifWin) begin
      strb.id   = ID_IF;
      strb.wide = 1'b1;
      strb.rd   = ifOk;
      strb.wr   = 1'b0;
      memLine   = ifAddr[AW-1:WOFF];
    end
  end

  assign dmaGnt = dmaWin;
  assign lsGnt  = lsWin;
  assign ifGnt  = ifWin;
  assign dmaErr = dmaWin & ~dmaOk;
  assign lsErr  = lsWin & ~lsOk;
  assign ifErr  = ifWin & ~ifOk;

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaGnt, lsGnt, ifGnt}));
  // R2
  prio_ls_chk: assert property (@(posedge clk) disable iff (!rstN)
    lsGnt |-> !dmaReq);
  // R2
  prio_if_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifGnt |-> (!dmaReq && !lsReq));
endmodule

// File: rtl/sparb_datapath.sv
module sparb_datapath
  import sparb_pkg::*;
#(
  parameter int MEM_BYTES    = 262144,
  parameter int NARROW_BYTES = 16,
  parameter int WIDE_BYTES   = 128,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int WOFF  = $clog2(WIDE_BYTES),
  localparam int NOFF  = $clog2(NARROW_BYTES),
  localparam int LW    = AW - WOFF,
  localparam int SW    = WOFF - NOFF,
  localparam int LINES = MEM_BYTES / WIDE_BYTES,
  localparam int SEGS  = WIDE_BYTES / NARROW_BYTES,
  localparam int WW    = WIDE_BYTES * 8,
  localparam int NW    = NARROW_BYTES * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  memStrb_t      strb,
  input  logic [LW-1:0] memLine,
  input  logic [SW-1:0] memSeg,
  input  logic [WW-1:0] dmaWdata,
  input  logic [NW-1:0] lsWdata,
  output logic          rdValid,
  output reqId_e        rdTag,
  output logic [WW-1:0] rdData
);
  logic [WW-1:0] memArr [LINES];
  logic [WW-1:0] rdWord;
  logic [NW-1:0] segWords [SEGS];
  logic [WW-1:0] stageIn;

  logic [RD_LAT-1:0] pipeV;
  reqId_e            pipeT [RD_LAT];
  logic [WW-1:0]     pipeD [RD_LAT];

  always_ff @(posedge clk) begin
    if (strb.wr) begin
      if (strb.wide) memArr[memLine] <= dmaWdata;
      else           memArr[memLine][memSeg*NW +: NW] <= lsWdata;
    end
  end

  assign rdWord = memArr[memLine];

  genvar g;
  for (g = 0; g < SEGS; g++) begin : gSeg
    assign segWords[g] = rdWord[g*NW +: NW];
  end

  assign stageIn = strb.wide ? rdWord : {{(WW-NW){1'b0}}, segWords[memSeg]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipeV <= '0;
    else       pipeV <= {pipeV[RD_LAT-2:0], strb.rd};
  end

  always_ff @(posedge clk) begin
    pipeT[0] <= strb.id;
    pipeD[0] <= stageIn;
    for (int i = 1; i < RD_LAT; i++) begin
      pipeT[i] <= pipeT[i-1];
      pipeD[i] <= pipeD[i-1];
    end
  end

  assign rdValid = pipeV[RD_LAT-1];
  assign rdTag   = pipeT[RD_LAT-1];
  assign rdData  = pipeD[RD_LAT-1];

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.rd, RD_LAT));
  // R7
  rd_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdTag == $past(strb.id, RD_LAT)));
  // R8
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdTag == ID_LS) |-> (rdData[WW-1:NW] == '0));
endmodule

// File: rtl/scratch_arbiter.sv
module scratch_arbiter
  import sparb_pkg::*;
#(
  parameter int MEM_BYTES    = 262144,
  parameter int NARROW_BYTES = 16,
  parameter int WIDE_BYTES   = 128,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int WOFF = $clog2(WIDE_BYTES),
  localparam int NOFF = $clog2(NARROW_BYTES),
  localparam int LW   = AW - WOFF,
  localparam int SW   = WOFF - NOFF,
  localparam int WW   = WIDE_BYTES * 8,
  localparam int NW   = NARROW_BYTES * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dmaReq,
  input  logic          dmaWr,
  input  logic [AW-1:0] dmaAddr,
  input  logic [WW-1:0] dmaWdata,
  output logic          dmaGnt,
  output logic          dmaErr,
  input  logic          lsReq,
  input  logic          lsWr,
  input  logic [AW-1:0] lsAddr,
  input  logic [NW-1:0] lsWdata,
  output logic          lsGnt,
  output logic          lsErr,
  input  logic          ifReq,
  input  logic [AW-1:0] ifAddr,
  output logic          ifGnt,
  output logic          ifErr,
  output logic          rdValid,
  output logic [1:0]    rdTag,
  output logic [WW-1:0] rdData
);
  memStrb_t      strb;
  logic [LW-1:0] memLine;
  logic [SW-1:0] memSeg;
  reqId_e        tagE;

  sparb_ctrl #(
    .MEM_BYTES(MEM_BYTES), .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .dmaReq(dmaReq), .dmaWr(dmaWr), .dmaAddr(dmaAddr),
    .lsReq(lsReq), .lsWr(lsWr), .lsAddr(lsAddr),
    .ifReq(ifReq), .ifAddr(ifAddr),
    .dmaGnt(dmaGnt), .lsGnt(lsGnt), .ifGnt(ifGnt),
    .dmaErr(dmaErr), .lsErr(lsErr), .ifErr(ifErr),
    .strb(strb), .memLine(memLine), .memSeg(memSeg)
  );

  sparb_datapath #(
    .MEM_BYTES(MEM_BYTES), .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memLine(memLine), .memSeg(memSeg),
    .dmaWdata(dmaWdata), .lsWdata(lsWdata),
    .rdValid(rdValid), .rdTag(tagE), .rdData(rdData)
  );

  assign rdTag = tagE;

  // R9
  err_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaErr || lsErr || ifErr) |-> !(strb.rd || strb.wr));
endmodule

// File: tb/scratch_arbiter_bench.sv
module scratch_arbiter_bench;
  localparam int MEMB  = 16384;
  localparam int AW    = 14;
  localparam int LINES = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dReq = 0, dWr = 0, lReq = 0, lWr = 0, iReq = 0;
  logic [AW-1:0] dAddr = '0, lAddr = '0, iAddr = '0;
  logic [1023:0] dData = '0;
  logic [127:0]  lData = '0;
  logic dmaGnt, dmaErr, lsGnt, lsErr, ifGnt, ifErr, rdValid;
  logic [1:0] rdTag;
  logic [1023:0] rdData;

  scratch_arbiter #(.MEM_BYTES(MEMB)) u_scratch_arbiter (
    .clk(clk), .rstN(rstN),
    .dmaReq(dReq), .dmaWr(dWr), .dmaAddr(dAddr), .dmaWdata(dData),
    .dmaGnt(dmaGnt), .dmaErr(dmaErr),
    .lsReq(lReq), .lsWr(lWr), .lsAddr(lAddr), .lsWdata(lData),
    .lsGnt(lsGnt), .lsErr(lsErr),
    .ifReq(iReq), .ifAddr(iAddr), .ifGnt(ifGnt), .ifErr(ifErr),
    .rdValid(rdValid), .rdTag(rdTag), .rdData(rdData)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, randomOn = 0;
  bit dDone = 0, lDone = 0, iDone = 0;
  logic [1023:0] model [LINES];
  bit            schV [8];
  logic [1:0]    schT [8];
  logic [1023:0] schD [8];

  task automatic chk(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  function automatic logic [1023:0] rndWide();
    logic [1023:0] v;
    for (int k = 0; k < 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [127:0] rndNarrow();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [AW-1:0] wideAddr(input bit bad);
    logic [AW-1:0] a;
    a = {7'($urandom % LINES), 7'd0};
    if (bad) a[6:0] = 7'(1 + $urandom % 127);
    return a;
  endfunction

  function automatic logic [AW-1:0] narrowAddr(input bit bad);
    logic [AW-1:0] a;
    a = {7'($urandom % LINES), 3'($urandom), 4'd0};
    if (bad) a[3:0] = 4'(1 + $urandom % 15);
    return a;
  endfunction

  task automatic refill();
    if (!dReq && ($urandom % 3 == 0)) begin
      dReq = 1; dWr = $urandom % 2; dAddr = wideAddr($urandom % 20 == 0); dData = rndWide();
    end
    if (!lReq && ($urandom % 2 == 0)) begin
      lReq = 1; lWr = $urandom % 2; lAddr = narrowAddr($urandom % 20 == 0); lData = rndNarrow();
    end
    if (!iReq && ($urandom % 2 == 0)) begin
      iReq = 1; iAddr = wideAddr($urandom % 20 == 0);
    end
  endtask

  task automatic sched(input logic [1:0] t, input logic [1023:0] d);
    schV[(cyc + 6) % 8] = 1;
    schT[(cyc + 6) % 8] = t;
    schD[(cyc + 6) % 8] = d;
  endtask

  // one clock: check at negedge, update model, advance, then change inputs
  task automatic step();
    logic [2:0] expG, expE;
    bit misD, misL, misI;
    int slot;
    @(negedge clk);
    misD = (dAddr[6:0] != 0);
    misL = (lAddr[3:0] != 0);
    misI = (iAddr[6:0] != 0);
    expG = {iReq & ~dReq & ~lReq, lReq & ~dReq, dReq};
    // R1 R2 R3
    chk({ifGnt, lsGnt, dmaGnt} == expG, "R1 R2 R3 grant",
        $sformatf("%b", {ifGnt, lsGnt, dmaGnt}), $sformatf("%b", expG));
    expE = expG & {misI, misL, misD};
    chk({ifErr, lsErr, dmaErr} == expE, "R9 error",
        $sformatf("%b", {ifErr, lsErr, dmaErr}), $sformatf("%b", expE));
    slot = cyc % 8;
    chk(rdValid == schV[slot], "R6 R9 R11 read valid",
        $sformatf("%b", rdValid), $sformatf("%b", schV[slot]));
    if (schV[slot] && rdValid) begin
      chk(rdTag == schT[slot], "R7 read tag",
          $sformatf("%0d", rdTag), $sformatf("%0d", schT[slot]));
      chk(rdData == schD[slot], "R4 R5 R8 read data",
          $sformatf("%h", rdData), $sformatf("%h", schD[slot]));
    end
    schV[slot] = 0;
    if (expG[0]) begin
      if (!misD) begin
        if (dWr) model[dAddr[13:7]] = dData;
        else     sched(2'd0, model[dAddr[13:7]]);
      end
      dDone = 1;
    end
    if (expG[1]) begin
      if (!misL) begin
        if (lWr) model[lAddr[13:7]][lAddr[6:4]*128 +: 128] = lData;
        else     sched(2'd1, {896'd0, model[lAddr[13:7]][lAddr[6:4]*128 +: 128]});
      end
      lDone = 1;
    end
    if (expG[2]) begin
      if (!misI) sched(2'd2, model[iAddr[13:7]]);
      iDone = 1;
    end
    @(posedge clk);
    cyc++;
    #1;
    if (dDone) begin dReq = 0; dDone = 0; end
    if (lDone) begin lReq = 0; lDone = 0; end
    if (iDone) begin iReq = 0; iDone = 0; end
    if (randomOn) refill();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1023:0] keep;
    logic [127:0]  seg;
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) schV[k] = 0;
    // R10 reset: requests high, nothing may be granted
    dReq = 1; lReq = 1; iReq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ifGnt, lsGnt, dmaGnt, dmaErr, lsErr, ifErr, rdValid} == 7'd0, "R10 reset outputs",
        $sformatf("%b", {ifGnt, lsGnt, dmaGnt, dmaErr, lsErr, ifErr, rdValid}), "0000000");
    dReq = 0; lReq = 0; iReq = 0;
    @(posedge clk); #1;
    rstN = 1;
    // R4: fill every line with bulk writes
    for (int ln = 0; ln < LINES; ln++) begin
      dReq = 1; dWr = 1; dAddr = {7'(ln), 7'd0}; dData = rndWide();
      step();
    end
    // R2 R3 R6 R7 R8: all three reads at once, served DMA, LS, fetch
    dReq = 1; dWr = 0; dAddr = {7'd5, 7'd0};
    lReq = 1; lWr = 0; lAddr = {7'd9, 3'd7, 4'd0};
    iReq = 1; iAddr = {7'd100, 7'd0};
    repeat (10) step();
    // R5: narrow write into segment 3, then a wide read shows only that segment changed
    keep = model[12];
    seg  = rndNarrow();
    lReq = 1; lWr = 1; lAddr = {7'd12, 3'd3, 4'd0}; lData = seg;
    step();
    dReq = 1; dWr = 0; dAddr = {7'd12, 7'd0};
    step();
    keep[3*128 +: 128] = seg;
    chk(model[12] == keep, "R5 model segment", "model", "one segment changed");
    repeat (7) step();
    // R9: misaligned on every requester at once, then one at a time
    dReq = 1; dWr = 1; dAddr = {7'd20, 7'd64}; dData = rndWide();
    lReq = 1; lWr = 1; lAddr = {7'd21, 3'd2, 4'd8}; lData = rndNarrow();
    iReq = 1; iAddr = {7'd22, 7'd16};
    repeat (4) step();
    lReq = 1; lWr = 0; lAddr = {7'd20, 3'd0, 4'd0};
    repeat (8) step();
    // random traffic
    randomOn = 1;
    repeat (3000) step();
    randomOn = 0;
    repeat (10) step();
    // R3: every request ever raised has been served
    chk(!dReq && !lReq && !iReq, "R3 all served",
        $sformatf("%b", {dReq, lReq, iReq}), "000");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule